// File: doc/BRIEF.md
# Eight-bit arithmetic/logic unit with status flags

This block is the arithmetic and logic datapath of an accumulator machine. Each cycle it takes the accumulator value, a second operand from a holding register, a carry input and a 4-bit operation code, and produces an 8-bit result combinationally. The same cycle it derives five status bits from the operation: sign, zero, nibble carry, even parity and carry. These bits are packed into a status byte that is registered on the rising clock edge whenever the write enable is high.

Subtraction goes through the same binary adder as addition, by adding the two's complement of the second operand. After any subtraction the carry bit means "a borrow occurred". Some operation classes touch only part of the status byte and some touch none of it. Compare sets the flags the way a subtraction does but returns the accumulator unchanged. A pass-through operation moves the second operand to the result and leaves every flag alone, so data moves can share the datapath.

Top module: `alu8_core`

## Requirements
- R1: Operation code 0h (add) gives result = (op_a + op_b) mod 256, and code 1h (add with carry) gives (op_a + op_b + carry_in) mod 256. The carry flag is set to the carry out of bit 7.
- R2: Code 2h (subtract) gives (op_a − op_b) mod 256, and code 3h (subtract with borrow) gives (op_a − op_b − carry_in) mod 256. The carry flag is 1 exactly when the true difference is negative.
- R3: Every flag-updating operation except a rotate sets the sign flag to bit 7 of its 8-bit value. It sets the zero flag to 1 only when that value is 00h. For compare, "its value" is the difference.
- R4: The nibble-carry flag is set on a carry out of bit 3 in add, add-with-carry and increment. In subtract, subtract-with-borrow, compare and decrement it is set on a borrow from bit 4 into bit 3, that is, when low nibble of op_a < low nibble of op_b plus borrow-in.
- R5: The parity flag is 1 when the value has an even number of 1 bits and 0 when the count is odd.
- R6: Status byte layout: sign = bit 7, zero = bit 6, nibble carry = bit 4, parity = bit 2, carry = bit 0. Bits 5, 3 and 1 always read 0, and reset (rst_n low) clears the byte to 00h.
- R7: Codes 4h (AND), 5h (OR) and 6h (XOR) return the bitwise result of op_a and op_b. They update sign, zero and parity, and clear both the carry and the nibble-carry flags.
- R8: Code 7h (compare) sets all five flags exactly as subtract would, and drives result = op_a.
- R9: Code 8h (increment) gives op_a + 1 and code 9h (decrement) gives op_a − 1, both mod 256. They update sign, zero, nibble carry and parity, and keep the carry flag unchanged.
- R10: The four rotates change only the carry flag.
  - Code Bh rotates left: bit 7 goes to bit 0 and to carry.
  - Code Ch rotates right: bit 0 goes to bit 7 and to carry.
  - Code Dh rotates left through carry_in: result = {op_a[6:0], carry_in}, and carry = op_a[7].
  - Code Eh rotates right through carry_in: result = {carry_in, op_a[7:1]}, and carry = op_a[0].
- R11: Code Ah (complement) gives ~op_a and code Fh (pass) gives op_b. Neither changes any flag, even with flag_we high.
- R12: When flag_we is low, the status byte holds its value across the clock edge whatever the operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the status byte loads on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the status byte |
| op_a | input | 8 | Accumulator operand |
| op_b | input | 8 | Holding-register operand |
| carry_in | input | 1 | Carry/borrow input for the carry-chained operations and rotates |
| op_sel | input | 4 | Operation code (see R1 to R11) |
| flag_we | input | 1 | Allows the status byte to load on this edge |
| result | output | 8 | Combinational 8-bit result |
| flags | output | 8 | Registered status byte |

## Verification
The bench builds the block with its default data width of 8. At that width the nibble boundary at bit 3 and the byte wrap at bit 7 are both exercised directly by operands such as 0Fh, FFh and 80h. A step-by-step model in the bench tracks the status byte across sequences of operations. This shows that partial-update classes (rotates, increment and decrement, complement, pass) keep the bits a previous operation left, and that a low enable freezes the whole byte.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int FLAG_W = 8;
    localparam int NIB_W  = 4;
    localparam int S_POS  = 7;
    localparam int Z_POS  = 6;
    localparam int AC_POS = 4;
    localparam int P_POS  = 2;
    localparam int CY_POS = 0;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_ADC  = 4'h1,
        OP_SUB  = 4'h2,
        OP_SBB  = 4'h3,
        OP_AND  = 4'h4,
        OP_OR   = 4'h5,
        OP_XOR  = 4'h6,
        OP_CMP  = 4'h7,
        OP_INC  = 4'h8,
        OP_DEC  = 4'h9,
        OP_NOT  = 4'hA,
        OP_RLC  = 4'hB,
        OP_RRC  = 4'hC,
        OP_RAL  = 4'hD,
        OP_RAR  = 4'hE,
        OP_PASS = 4'hF
    } alu_op_e;

    typedef enum logic [1:0] {
        CI_ZERO  = 2'd0,
        CI_ONE   = 2'd1,
        CI_PORT  = 2'd2,
        CI_NPORT = 2'd3
    } cin_sel_e;

    typedef enum logic [1:0] {
        RS_SUM   = 2'd0,
        RS_LOGIC = 2'd1,
        RS_A     = 2'd2,
        RS_B     = 2'd3
    } res_sel_e;

    typedef struct packed {
        logic     b_one;
        logic     b_inv;
        cin_sel_e cin;
        res_sel_e rsel;
        logic     upd_szp;
        logic     upd_ac;
        logic     upd_cy;
    } alu_ctl_s;

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         inv_b,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ncout
);
    localparam int LW = NIB_W;
    localparam int HW = W - LW;

    logic [W-1:0] bx;
    logic [LW:0]  lo;
    logic [HW:0]  hi;

    assign bx = inv_b ? ~b : b;

    always_comb begin
        lo = {1'b0, a[LW-1:0]} + {1'b0, bx[LW-1:0]} + {{LW{1'b0}}, cin};
        hi = {1'b0, a[W-1:LW]} + {1'b0, bx[W-1:LW]} + {{HW{1'b0}}, lo[LW]};
    end

    assign sum   = {hi[HW-1:0], lo[LW-1:0]};
    assign cout  = hi[HW];
    assign ncout = lo[LW];

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cy
);
    always_comb begin
        res = a;
        cy  = 1'b0;
        unique case (op)
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_NOT: res = ~a;
            OP_RLC: begin
                res = {a[W-2:0], a[W-1]};
                cy  = a[W-1];
            end
            OP_RRC: begin
                res = {a[0], a[W-1:1]};
                cy  = a[0];
            end
            OP_RAL: begin
                res = {a[W-2:0], cin};
                cy  = a[W-1];
            end
            OP_RAR: begin
                res = {cin, a[W-1:1]};
                cy  = a[0];
            end
            default: begin
                res = a;
                cy  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              upd_szp,
    input  logic              upd_ac,
    input  logic              upd_cy,
    input  logic              s_in,
    input  logic              z_in,
    input  logic              ac_in,
    input  logic              p_in,
    input  logic              cy_in,
    output logic [FLAG_W-1:0] flags
);
    logic s_q, z_q, ac_q, p_q, cy_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q  <= 1'b0;
            z_q  <= 1'b0;
            ac_q <= 1'b0;
            p_q  <= 1'b0;
            cy_q <= 1'b0;
        end else if (we) begin
            if (upd_szp) begin
                s_q <= s_in;
                z_q <= z_in;
                p_q <= p_in;
            end
            if (upd_ac) ac_q <= ac_in;
            if (upd_cy) cy_q <= cy_in;
        end
    end

    always_comb begin
        flags         = '0;
        flags[S_POS]  = s_q;
        flags[Z_POS]  = z_q;
        flags[AC_POS] = ac_q;
        flags[P_POS]  = p_q;
        flags[CY_POS] = cy_q;
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              carry_in,
    input  logic [3:0]        op_sel,
    input  logic              flag_we,
    output logic [DATA_W-1:0] result,
    output logic [FLAG_W-1:0] flags
);
    alu_op_e           op;
    alu_ctl_s          ctl;
    logic [DATA_W-1:0] add_b;
    logic              add_cin;
    logic [DATA_W-1:0] sum;
    logic              cout;
    logic              ncout;
    logic [DATA_W-1:0] lg_res;
    logic              lg_cy;
    logic [DATA_W-1:0] flag_src;
    logic              ac_val;
    logic              cy_val;
    logic              cur_cy;

    assign op     = alu_op_e'(op_sel);
    assign cur_cy = flags[CY_POS];

    // Operation class decode
    always_comb begin
        ctl = '{b_one: 1'b0, b_inv: 1'b0, cin: CI_ZERO, rsel: RS_SUM,
                upd_szp: 1'b1, upd_ac: 1'b1, upd_cy: 1'b1};
        unique case (op)
            OP_ADD:  ctl.cin = CI_ZERO;
            OP_ADC:  ctl.cin = CI_PORT;
            OP_SUB: begin
                ctl.b_inv = 1'b1;
                ctl.cin   = CI_ONE;
            end
            OP_SBB: begin
                ctl.b_inv = 1'b1;
                ctl.cin   = CI_NPORT;
            end
            OP_CMP: begin
                ctl.b_inv = 1'b1;
                ctl.cin   = CI_ONE;
                ctl.rsel  = RS_A;
            end
            OP_INC: begin
                ctl.b_one  = 1'b1;
                ctl.upd_cy = 1'b0;
            end
            OP_DEC: begin
                ctl.b_one  = 1'b1;
                ctl.b_inv  = 1'b1;
                ctl.cin    = CI_ONE;
                ctl.upd_cy = 1'b0;
            end
            OP_AND, OP_OR, OP_XOR: ctl.rsel = RS_LOGIC;
            OP_NOT: begin
                ctl.rsel    = RS_LOGIC;
                ctl.upd_szp = 1'b0;
                ctl.upd_ac  = 1'b0;
                ctl.upd_cy  = 1'b0;
            end
            OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
                ctl.rsel    = RS_LOGIC;
                ctl.upd_szp = 1'b0;
                ctl.upd_ac  = 1'b0;
            end
            OP_PASS: begin
                ctl.rsel    = RS_B;
                ctl.upd_szp = 1'b0;
                ctl.upd_ac  = 1'b0;
                ctl.upd_cy  = 1'b0;
            end
            default: ctl.rsel = RS_SUM;
        endcase
    end

    assign add_b = ctl.b_one ? DATA_W'(1) : op_b;

    always_comb begin
        unique case (ctl.cin)
            CI_ZERO:  add_cin = 1'b0;
            CI_ONE:   add_cin = 1'b1;
            CI_PORT:  add_cin = carry_in;
            CI_NPORT: add_cin = ~carry_in;
            default:  add_cin = 1'b0;
        endcase
    end

    alu8_adder #(.W(DATA_W)) u_adder (
        .a     (op_a),
        .b     (add_b),
        .cin   (add_cin),
        .inv_b (ctl.b_inv),
        .sum   (sum),
        .cout  (cout),
        .ncout (ncout)
    );

    alu8_logic #(.W(DATA_W)) u_logic (
        .op  (op),
        .a   (op_a),
        .b   (op_b),
        .cin (carry_in),
        .res (lg_res),
        .cy  (lg_cy)
    );

    // Result select
    always_comb begin
        unique case (ctl.rsel)
            RS_SUM:   result = sum;
            RS_LOGIC: result = lg_res;
            RS_A:     result = op_a;
            RS_B:     result = op_b;
            default:  result = sum;
        endcase
    end

    // Flag sources: compare uses the difference, not the returned value
    always_comb begin
        if (ctl.rsel == RS_LOGIC) begin
            flag_src = lg_res;
            ac_val   = 1'b0;
            cy_val   = lg_cy;
        end else begin
            flag_src = sum;
            ac_val   = ctl.b_inv ? ~ncout : ncout;
            cy_val   = ctl.upd_cy ? (ctl.b_inv ? ~cout : cout) : cur_cy;
        end
    end

    alu8_flagreg u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (flag_we),
        .upd_szp (ctl.upd_szp),
        .upd_ac  (ctl.upd_ac),
        .upd_cy  (ctl.upd_cy),
        .s_in    (flag_src[DATA_W-1]),
        .z_in    (flag_src == '0),
        .ac_in   (ac_val),
        .p_in    (~^flag_src),
        .cy_in   (cy_val),
        .flags   (flags)
    );

endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
    import alu8_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] op_a,
    input logic [3:0] op_sel,
    input logic       flag_we,
    input logic [7:0] result,
    input logic [7:0] flags
);
    // R12
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable(flags));

    // R6
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> (flags[5] == 1'b0 && flags[3] == 1'b0 && flags[1] == 1'b0));

    // R11
    no_flag_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && (op_sel == OP_NOT || op_sel == OP_PASS)) |=> $stable(flags));

    // R10
    rotate_cy_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && (op_sel == OP_RLC || op_sel == OP_RRC ||
                     op_sel == OP_RAL || op_sel == OP_RAR))
        |=> (flags[7:1] == $past(flags[7:1])));

    // R8
    cmp_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_CMP) |-> (result == op_a));

    // R7
    logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR))
        |=> (flags[0] == 1'b0 && flags[4] == 1'b0));

    // R3
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_sel == OP_ADD) |=> (flags[6] == ($past(result) == 8'h00)));

    // R5
    parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_sel == OP_XOR) |=> (flags[2] == ~^$past(result)));

    // R9
    incdec_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && (op_sel == OP_INC || op_sel == OP_DEC)) |=> $stable(flags[0]));

endmodule

bind alu8_core alu8_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_a    (op_a),
    .op_sel  (op_sel),
    .flag_we (flag_we),
    .result  (result),
    .flags   (flags)
);

// File: tb/tb_alu8_core.sv
`timescale 1ns/100ps
module tb_alu8_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] op_a = 8'h00;
    logic [7:0] op_b = 8'h00;
    logic       carry_in = 1'b0;
    logic [3:0] op_sel = 4'hF;
    logic       flag_we = 1'b0;
    logic [7:0] result;
    logic [7:0] flags;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_flags = 8'h00;

    always #2.5 clk = ~clk;

    alu8_core dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .carry_in(carry_in), .op_sel(op_sel), .flag_we(flag_we),
        .result(result), .flags(flags)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Model built from the requirements; flag bits S7 Z6 AC4 P2 CY0
    task automatic model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic c, input logic [7:0] fl,
                         output logic [7:0] r, output logic [7:0] nf);
        int v;
        int bin;
        logic [7:0] fv;
        logic szp, ac_up, cy_up, ac, cy;
        nf = fl; szp = 0; ac_up = 0; cy_up = 0; ac = 0; cy = 0; fv = 0; r = a;
        case (op)
            4'h0, 4'h1: begin
                bin = (op == 4'h1) ? int'(c) : 0;
                v = int'(a) + int'(b) + bin;
                r = v[7:0]; fv = r; cy = v > 255;
                ac = (int'(a[3:0]) + int'(b[3:0]) + bin) > 15;
                szp = 1; ac_up = 1; cy_up = 1;
            end
            4'h2, 4'h3, 4'h7: begin
                bin = (op == 4'h3) ? int'(c) : 0;
                v = int'(a) - int'(b) - bin;
                fv = v[7:0]; r = (op == 4'h7) ? a : v[7:0]; cy = v < 0;
                ac = int'(a[3:0]) < (int'(b[3:0]) + bin);
                szp = 1; ac_up = 1; cy_up = 1;
            end
            4'h4, 4'h5, 4'h6: begin
                r = (op == 4'h4) ? (a & b) : (op == 4'h5) ? (a | b) : (a ^ b);
                fv = r; szp = 1; ac_up = 1; cy_up = 1;
            end
            4'h8: begin r = a + 8'd1; fv = r; ac = (a[3:0] == 4'hF); szp = 1; ac_up = 1; end
            4'h9: begin r = a - 8'd1; fv = r; ac = (a[3:0] == 4'h0); szp = 1; ac_up = 1; end
            4'hA: r = ~a;
            4'hB: begin r = {a[6:0], a[7]}; cy = a[7]; cy_up = 1; end
            4'hC: begin r = {a[0], a[7:1]}; cy = a[0]; cy_up = 1; end
            4'hD: begin r = {a[6:0], c}; cy = a[7]; cy_up = 1; end
            4'hE: begin r = {c, a[7:1]}; cy = a[0]; cy_up = 1; end
            default: r = b;
        endcase
        if (szp) begin
            nf[7] = fv[7];
            nf[6] = (fv == 8'h00);
            nf[2] = ~^fv;
        end
        if (ac_up) nf[4] = ac;
        if (cy_up) nf[0] = cy;
    endtask

    // Drive one operation after a falling edge, check result, then flags after the rising edge
    task automatic run(input string tag, input logic [3:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic c, input logic we);
        logic [7:0] er, ef;
        @(negedge clk);
        op_sel = op; op_a = a; op_b = b; carry_in = c; flag_we = we;
        model(op, a, b, c, exp_flags, er, ef);
        #1;
        chk({tag, " result"}, result, er);
        @(posedge clk);
        #1;
        if (we) exp_flags = ef;
        chk({tag, " flags"}, flags, exp_flags);
    endtask

    task automatic t_reset();
        chk("R6 reset flags", flags, 8'h00);
    endtask

    task automatic t_add();
        run("R1 add 45+F3", 4'h0, 8'h45, 8'hF3, 1'b0, 1'b1);
        chk("R1 add carry set", {7'b0, flags[0]}, 8'h01);
        run("R1 add 85+1E", 4'h0, 8'h85, 8'h1E, 1'b0, 1'b1);
        chk("R1 add carry clear", {7'b0, flags[0]}, 8'h00);
        run("R4 add 2B+39", 4'h0, 8'h2B, 8'h39, 1'b0, 1'b1);
        chk("R4 nibble carry", {7'b0, flags[4]}, 8'h01);
        run("R1 adc FF+00+1", 4'h1, 8'hFF, 8'h00, 1'b1, 1'b1);
        chk("R3 zero on wrap", {7'b0, flags[6]}, 8'h01);
    endtask

    task automatic t_sub();
        run("R2 sub 30-40", 4'h2, 8'h30, 8'h40, 1'b0, 1'b1);
        chk("R3 sign set", {7'b0, flags[7]}, 8'h01);
        chk("R2 borrow set", {7'b0, flags[0]}, 8'h01);
        run("R2 sub 40-30", 4'h2, 8'h40, 8'h30, 1'b0, 1'b1);
        chk("R3 sign clear", {7'b0, flags[7]}, 8'h00);
        run("R3 sub 10-10", 4'h2, 8'h10, 8'h10, 1'b0, 1'b1);
        chk("R3 zero set", {7'b0, flags[6]}, 8'h01);
        run("R2 sbb 10-00-1", 4'h3, 8'h10, 8'h00, 1'b1, 1'b1);
        chk("R4 borrow into bit3", {7'b0, flags[4]}, 8'h01);
    endtask

    task automatic t_logic();
        run("R2 setup carry", 4'h2, 8'h00, 8'h01, 1'b0, 1'b1);
        run("R5 or 05", 4'h5, 8'h05, 8'h00, 1'b0, 1'b1);
        chk("R5 parity even", {7'b0, flags[2]}, 8'h01);
        chk("R7 carry cleared", {7'b0, flags[0]}, 8'h00);
        run("R7 and", 4'h4, 8'hF0, 8'h3C, 1'b0, 1'b1);
        run("R5 xor odd", 4'h6, 8'h07, 8'h00, 1'b0, 1'b1);
        chk("R5 parity odd", {7'b0, flags[2]}, 8'h00);
    endtask

    task automatic t_cmp();
        run("R8 cmp 20 vs 21", 4'h7, 8'h20, 8'h21, 1'b0, 1'b1);
        run("R8 cmp equal", 4'h7, 8'h5A, 8'h5A, 1'b0, 1'b1);
        chk("R8 cmp zero", {7'b0, flags[6]}, 8'h01);
    endtask

    task automatic t_incdec();
        run("R2 carry on", 4'h0, 8'hFF, 8'h01, 1'b0, 1'b1);
        run("R9 inc 0F", 4'h8, 8'h0F, 8'h00, 1'b0, 1'b1);
        chk("R9 carry kept", {7'b0, flags[0]}, 8'h01);
        run("R9 inc FF", 4'h8, 8'hFF, 8'h00, 1'b0, 1'b1);
        run("R9 dec 00", 4'h9, 8'h00, 8'h00, 1'b0, 1'b1);
        run("R9 dec 81", 4'h9, 8'h81, 8'h00, 1'b0, 1'b1);
    endtask

    task automatic t_rotate();
        run("R10 setup", 4'h0, 8'h80, 8'h80, 1'b0, 1'b1);
        run("R10 rlc", 4'hB, 8'h81, 8'h00, 1'b0, 1'b1);
        run("R10 rrc", 4'hC, 8'h02, 8'h00, 1'b1, 1'b1);
        run("R10 ral", 4'hD, 8'h40, 8'h00, 1'b1, 1'b1);
        run("R10 rar", 4'hE, 8'h01, 8'h00, 1'b0, 1'b1);
    endtask

    task automatic t_noflag();
        run("R11 setup", 4'h2, 8'h00, 8'h01, 1'b0, 1'b1);
        run("R11 not", 4'hA, 8'h00, 8'h00, 1'b0, 1'b1);
        run("R11 pass", 4'hF, 8'h11, 8'h00, 1'b0, 1'b1);
    endtask

    task automatic t_hold();
        run("R12 hold add", 4'h0, 8'hFF, 8'h01, 1'b0, 1'b0);
        run("R12 hold sub", 4'h2, 8'h00, 8'h00, 1'b0, 1'b0);
        run("R12 hold xor", 4'h6, 8'h0F, 8'hF0, 1'b1, 1'b0);
    endtask

    task automatic t_sweep();
        logic [7:0] pa [6] = '{8'h00, 8'h0F, 8'h7F, 8'h80, 8'hFF, 8'hA5};
        logic [7:0] pb [6] = '{8'hFF, 8'h01, 8'h01, 8'h80, 8'h0F, 8'h5A};
        for (int o = 0; o < 16; o++) begin
            for (int i = 0; i < 6; i++) begin
                run("R1 R2 R7 R9 R10 sweep", 4'(o), pa[i], pb[i], 1'(i), 1'b1);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_add();
        t_sub();
        t_logic();
        t_cmp();
        t_incdec();
        t_rotate();
        t_noflag();
        t_hold();
        t_sweep();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule